// File: doc/BRIEF.md
# SDLC Frame Status Queue

This block sits beside a bit-oriented HDLC/SDLC receiver. While a DMA engine moves received bytes to memory, the block keeps a record for each frame so that software can check that frame later. A 14-bit counter counts received bytes within the current frame. When the closing flag ends the frame, the final count and five error bits are queued together as one record. The error bits are three residue bits, an overrun bit and a CRC error bit.

Software reads the oldest record through three byte-wide register views. The status view overlays the queued residue, overrun, CRC-error and end-of-frame bits on the live receiver status. The two count views give the queued byte count, together with an overflow flag and a record-available flag. Software then pulses a read-complete strobe to release the record. When the queue is disabled, the views show the live receiver state and the queue is emptied.

Top module: `sdlc_frame_status_queue`

## Requirements
- R1: In SDLC mode, each byte strobe raises the running byte count by one, and the count wraps from 16383 to 0.
- R2: In SDLC mode, a flag strobe clears the running count. It takes priority over a byte strobe in the same cycle.
- R3: With SDLC mode low, the running count holds its value under byte and flag strobes, and an end-of-frame strobe queues nothing.
- R4: With the queue enabled, an end-of-frame strobe in SDLC mode stores the running count and the live residue, overrun and CRC-error bits as one record. The next cycle shows it as available (cnt_hi bit 6 = 1). Records leave in arrival order, and frames may follow each other with no gap.
- R5: A read-complete strobe releases the oldest record. A read-complete strobe while the queue is empty changes nothing.
- R6: Ten unread records are held. An 11th end-of-frame strobe is discarded and sets the sticky overflow flag (cnt_hi bit 7). The stored records are left unchanged, and the flag stays set after the queue is drained.
- R7: While fifo_en is low, the queue is emptied, the overflow flag is cleared and end-of-frame strobes store nothing.
- R8: Status view layout: bit 0 all-sent, bits 3:1 residue, bit 4 parity error, bit 5 overrun, bit 6 CRC error, bit 7 end-of-frame. When the queue is enabled and holds a record, bits 7:5 and 3:1 come from the oldest record, and bit 7 reads 1. Otherwise they show the live inputs.
- R9: Status view bits 0 and 4 always show the live all-sent and parity inputs.
- R10: cnt_lo shows count bits 7:0 and cnt_hi bits 5:0 show count bits 13:8. The count shown is the oldest record's count when one is available, and the running count otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue enable control bit |
| sdlc_mode | input | 1 | Receiver is in SDLC mode |
| byte_strobe | input | 1 | One received byte |
| flag_seen | input | 1 | Flag detected |
| frame_end | input | 1 | Closing flag ended a frame |
| live_residue | input | 3 | Live residue bits |
| live_overrun | input | 1 | Live receive overrun |
| live_crc_err | input | 1 | Live CRC error |
| live_eof | input | 1 | Live end-of-frame status |
| live_all_sent | input | 1 | Live all-sent status |
| live_parity | input | 1 | Live parity error |
| read_done | input | 1 | Status read complete, release oldest record |
| stat_view | output | 8 | Status register view |
| cnt_lo | output | 8 | Count bits 7:0 |
| cnt_hi | output | 8 | Overflow, available, count bits 13:8 |

## Verification
On every cycle, the assertions check the counter's step, clear and hold rules, the stickiness of overflow and the fact that it rises only on a push into a full queue, and the clearing effect of disable. They also check that end-of-frame reads 1 while a record is shown and that the all-sent and parity bits pass straight through. Only the bench's scenarios can show that records come back with the right counts and error bits in arrival order. The same holds for the count wrap at 16384, for back-to-back frames, and for the 11th frame being discarded while the first ten stay intact.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  parameter int CNT_W   = 14;
  parameter int RES_W   = 3;
  parameter int DEPTH   = 10;
  parameter int PTR_W   = 4;
  localparam int ENT_W  = CNT_W + RES_W + 2;
  localparam int LVL_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [RES_W-1:0] residue;
    logic             overrun;
    logic             crc_err;
  } fsq_entry_t;

  function automatic logic [PTR_W-1:0] fsq_ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] fsq_count_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic fsq_entry_t fsq_make_entry(input logic [CNT_W-1:0] c,
                                                input logic [RES_W-1:0] r,
                                                input logic o, input logic e);
    fsq_entry_t t;
    t.count = c; t.residue = r; t.overrun = o; t.crc_err = e;
    return t;
  endfunction
endpackage

// File: rtl/fsq_byte_counter.sv
module fsq_byte_counter
  import fsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdlc_mode,
  input  logic             byte_stb,
  input  logic             flag_stb,
  output logic [CNT_W-1:0] count
);
  logic do_clear, do_step;
  assign do_clear = sdlc_mode && flag_stb;
  assign do_step  = sdlc_mode && byte_stb && !flag_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (do_clear) count <= '0;
    else if (do_step)  count <= fsq_count_step(count);
  end
endmodule

// File: rtl/fsq_ring.sv
module fsq_ring
  import fsq_pkg::*;
#(
  parameter int N = DEPTH
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       push_req,
  input  logic       pop_req,
  input  fsq_entry_t wr_entry,
  output fsq_entry_t head_entry,
  output logic       avail,
  output logic       full,
  output logic       overflow,
  output logic [LVL_W-1:0] level
);
  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             head_lap, tail_lap;
  logic             ptr_equal, empty, push_ok, pop_ok;
  fsq_entry_t       mem [N];

  assign ptr_equal = (head_ptr == tail_ptr);
  assign empty     = ptr_equal && (head_lap == tail_lap);
  assign full      = ptr_equal && (head_lap != tail_lap);
  assign avail     = !empty;
  assign pop_ok    = enable && pop_req && !empty;
  assign push_ok   = enable && push_req && (!full || pop_ok);

  always_comb begin
    if (full)                    level = LVL_W'(N);
    else if (tail_ptr >= head_ptr) level = LVL_W'(tail_ptr - head_ptr);
    else                         level = LVL_W'(tail_ptr + PTR_W'(N) - head_ptr);
  end

  assign head_entry = mem[head_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr <= '0; tail_ptr <= '0;
      head_lap <= 1'b0; tail_lap <= 1'b0;
      overflow <= 1'b0;
    end else if (!enable) begin
      head_ptr <= '0; tail_ptr <= '0;
      head_lap <= 1'b0; tail_lap <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (pop_ok) begin
        head_ptr <= fsq_ptr_next(head_ptr);
        if (head_ptr == PTR_W'(N - 1)) head_lap <= !head_lap;
      end
      if (push_ok) begin
        tail_ptr <= fsq_ptr_next(tail_ptr);
        if (tail_ptr == PTR_W'(N - 1)) tail_lap <= !tail_lap;
      end
      if (push_req && !push_ok) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail_ptr] <= wr_entry;
  end
endmodule

// File: rtl/fsq_status_view.sv
module fsq_status_view
  import fsq_pkg::*;
(
  input  logic             sel_queue,
  input  fsq_entry_t       head_entry,
  input  logic [CNT_W-1:0] run_count,
  input  logic [RES_W-1:0] live_residue,
  input  logic             live_overrun,
  input  logic             live_crc_err,
  input  logic             live_eof,
  input  logic             live_all_sent,
  input  logic             live_parity,
  input  logic             overflow,
  input  logic             avail,
  output logic [7:0]       stat_view,
  output logic [7:0]       cnt_lo,
  output logic [7:0]       cnt_hi
);
  logic [5:0]       muxed;
  logic [CNT_W-1:0] shown_count;

  always_comb begin
    if (sel_queue) begin
      muxed       = {1'b1, head_entry.crc_err, head_entry.overrun, head_entry.residue};
      shown_count = head_entry.count;
    end else begin
      muxed       = {live_eof, live_crc_err, live_overrun, live_residue};
      shown_count = run_count;
    end
  end

  assign stat_view = {muxed[5:3], live_parity, muxed[2:0], live_all_sent};
  assign cnt_lo    = shown_count[7:0];
  assign cnt_hi    = {overflow, avail, shown_count[CNT_W-1:8]};
endmodule

// File: rtl/sdlc_frame_status_queue.sv
module sdlc_frame_status_queue
  import fsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       sdlc_mode,
  input  logic       byte_strobe,
  input  logic       flag_seen,
  input  logic       frame_end,
  input  logic [2:0] live_residue,
  input  logic       live_overrun,
  input  logic       live_crc_err,
  input  logic       live_eof,
  input  logic       live_all_sent,
  input  logic       live_parity,
  input  logic       read_done,
  output logic [7:0] stat_view,
  output logic [7:0] cnt_lo,
  output logic [7:0] cnt_hi
);
  logic [CNT_W-1:0] run_count;
  fsq_entry_t       wr_entry, head_entry;
  logic             push_req, avail, full, overflow, show_queue;
  logic [LVL_W-1:0] level;

  assign push_req   = fifo_en && sdlc_mode && frame_end;
  assign wr_entry   = fsq_make_entry(run_count, live_residue, live_overrun, live_crc_err);
  assign show_queue = fifo_en && avail;

  fsq_byte_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .sdlc_mode(sdlc_mode),
    .byte_stb(byte_strobe), .flag_stb(flag_seen), .count(run_count)
  );

  fsq_ring #(.N(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .enable(fifo_en), .push_req(push_req),
    .pop_req(read_done), .wr_entry(wr_entry), .head_entry(head_entry),
    .avail(avail), .full(full), .overflow(overflow), .level(level)
  );

  fsq_status_view u_view (
    .sel_queue(show_queue), .head_entry(head_entry), .run_count(run_count),
    .live_residue(live_residue), .live_overrun(live_overrun),
    .live_crc_err(live_crc_err), .live_eof(live_eof),
    .live_all_sent(live_all_sent), .live_parity(live_parity),
    .overflow(overflow), .avail(avail),
    .stat_view(stat_view), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker
  import fsq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             sdlc_mode,
  input logic             byte_strobe,
  input logic             flag_seen,
  input logic             push_req,
  input logic             full,
  input logic             overflow,
  input logic             avail,
  input logic [LVL_W-1:0] level,
  input logic [CNT_W-1:0] run_count,
  input logic [7:0]       stat_view,
  input logic             live_all_sent,
  input logic             live_parity
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sdlc_mode && byte_strobe && !flag_seen) |=> run_count == CNT_W'($past(run_count) + 1'b1)); // R1
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdlc_mode && flag_seen) |=> run_count == '0); // R2
  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdlc_mode) |=> $stable(run_count)); // R3
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && fifo_en) |=> overflow); // R6
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(push_req && full)); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en) |=> (!overflow && !avail)); // R7
  AST_EOF_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && avail) |-> stat_view[7]); // R8
  AST_LIVE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_view[0] == live_all_sent) && (stat_view[4] == live_parity)); // R9
endmodule

bind sdlc_frame_status_queue fsq_checker u_fsq_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sdlc_mode(sdlc_mode),
  .byte_strobe(byte_strobe), .flag_seen(flag_seen), .push_req(push_req),
  .full(full), .overflow(overflow), .avail(avail), .level(level),
  .run_count(run_count), .stat_view(stat_view),
  .live_all_sent(live_all_sent), .live_parity(live_parity)
);

// File: tb/test_sdlc_frame_status_queue.sv
module test_sdlc_frame_status_queue;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, sdlc_mode = 0, byte_strobe = 0, flag_seen = 0, frame_end = 0;
  logic [2:0] live_residue = 0;
  logic live_overrun = 0, live_crc_err = 0, live_eof = 0, live_all_sent = 0, live_parity = 0;
  logic read_done = 0;
  logic [7:0] stat_view, cnt_lo, cnt_hi;

  int n_checks = 0, n_fail = 0, model_level = 0;
  bit done = 0;
  logic [18:0] exp_q [$];

  always #5ns clk = ~clk;

  sdlc_frame_status_queue i_sdlc_frame_status_queue (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one frame of nbytes, closing flag carries the status; expected record queued
  task automatic send_frame(input int nbytes, input logic [2:0] res, input logic ovr,
                            input logic crc, input bit open_flag);
    if (open_flag) begin flag_seen = 1; @(negedge clk); flag_seen = 0; end
    byte_strobe = 1;
    repeat (nbytes) @(negedge clk);
    byte_strobe = 0;
    live_residue = res; live_overrun = ovr; live_crc_err = crc;
    frame_end = 1; flag_seen = 1;
    @(negedge clk);
    frame_end = 0; flag_seen = 0;
    live_residue = 0; live_overrun = 0; live_crc_err = 0;
    if (fifo_en && sdlc_mode && model_level < 10) begin
      exp_q.push_back({14'(nbytes), res, ovr, crc});
      model_level++;
    end
  endtask

  // monitor: compares the shown record with the oldest expected one, then releases it
  task automatic take_record(input string req);
    logic [18:0] exp, got;
    exp = exp_q.pop_front();
    got = {cnt_hi[5:0], cnt_lo, stat_view[3:1], stat_view[5], stat_view[6]};
    chk(req, got, exp);
    chk("R8 eof reads 1 from queue", stat_view[7], 1'b1);
    read_done = 1; @(negedge clk); read_done = 0;
    model_level--;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    live_eof = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset count/flags", {cnt_hi, cnt_lo}, 16'h0000);
    chk("R8 live eof when empty", stat_view[7], 1'b1);
    live_eof = 0;

    fifo_en = 1; sdlc_mode = 1;
    @(negedge clk);
    // R4 back-to-back frames
    send_frame(5, 3'b101, 1'b0, 1'b1, 1'b1);
    chk("R4 available after push", cnt_hi[6], 1'b1);
    send_frame(3, 3'b010, 1'b1, 1'b0, 1'b0);
    // R9 live bits while record shown
    live_all_sent = 1; live_parity = 1; #1;
    chk("R9 bypass bits", {stat_view[4], stat_view[0]}, 2'b11);
    live_all_sent = 0; live_parity = 0;
    take_record("R4 first record");
    take_record("R4 second record");
    chk("R5 empty after pops", cnt_hi[6], 1'b0);
    // R5 pop while empty
    read_done = 1; @(negedge clk); read_done = 0;
    chk("R5 empty pop keeps empty", cnt_hi[7:6], 2'b00);
    send_frame(7, 3'b011, 1'b1, 1'b1, 1'b1);
    take_record("R5 pointers intact after empty pop");

    // R1/R2 running count
    flag_seen = 1; @(negedge clk); flag_seen = 0;
    byte_strobe = 1; repeat (4) @(negedge clk);
    chk("R1 running count", cnt_lo, 8'd4);
    flag_seen = 1; @(negedge clk); byte_strobe = 0; flag_seen = 0;
    chk("R2 flag beats byte", cnt_lo, 8'd0);
    // R3 mode low
    byte_strobe = 1; @(negedge clk); byte_strobe = 0;
    sdlc_mode = 0;
    byte_strobe = 1; repeat (3) @(negedge clk); byte_strobe = 0;
    flag_seen = 1; @(negedge clk); flag_seen = 0;
    chk("R3 count holds", cnt_lo, 8'd1);
    frame_end = 1; @(negedge clk); frame_end = 0;
    chk("R3 no push outside mode", cnt_hi[6], 1'b0);
    sdlc_mode = 1;

    // R1 wrap
    send_frame(16385, 3'b111, 1'b0, 1'b0, 1'b1);
    take_record("R1 count wraps to 1");

    // R6 overflow on 11th
    for (int i = 1; i <= 10; i++) send_frame(i, 3'(i), 1'b0, 1'(i), 1'b1);
    chk("R6 ten held no overflow", cnt_hi[7:6], 2'b01);
    send_frame(11, 3'b000, 1'b1, 1'b1, 1'b1);
    chk("R6 overflow set", cnt_hi[7], 1'b1);
    for (int i = 1; i <= 10; i++) take_record("R6 stored records intact");
    chk("R6 overflow sticky after drain", cnt_hi[7:6], 2'b10);

    // R7 disable
    fifo_en = 0; @(negedge clk);
    chk("R7 disable clears overflow", cnt_hi[7], 1'b0);
    send_frame(2, 3'b001, 1'b0, 1'b0, 1'b1);
    chk("R7 no push while disabled", cnt_hi[6], 1'b0);
    live_eof = 1; live_residue = 3'b110; #1;
    chk("R8 live view when disabled", stat_view, 8'b1000_1100);
    live_eof = 0; live_residue = 0;
    fifo_en = 1; @(negedge clk);
    send_frame(4, 3'b001, 1'b0, 1'b0, 1'b1);
    send_frame(6, 3'b001, 1'b0, 1'b0, 1'b1);
    fifo_en = 0; @(negedge clk); fifo_en = 1;
    exp_q.delete(); model_level = 0;
    @(negedge clk);
    chk("R7 disable empties queue", cnt_hi[6], 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule